// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the page-write logic of a byte-wide nonvolatile memory. Each captured write (a 15-bit address, a data byte and a one-cycle strobe) passes through it. The block looks for the short command sequences that arm and disarm write protection, or that unlock a single write while protection is armed. For every byte it tells the write controller how to treat it:

- hold it as a possible command byte;
- store it as data;
- discard it as a completed command;
- treat it as a blocked write, which still starts the write timer but leaves memory unchanged.

While a sequence is partly matched, its bytes are held back. A completed command settles them as discarded. A byte that breaks the sequence, or a pause longer than the byte-load window, releases them. Released bytes are then handled as data, or as blocked writes when protection is armed.

The protection flag models a nonvolatile bit. It ignores the ordinary reset and is cleared only by a dedicated initial-state input. A new protection value is committed only when the write controller signals the end of the write cycle that follows the command. This holds even when no data bytes came after the command.

Command sequences use these fixed byte@address pairs (all values hexadecimal):

| Sequence | Steps |
|---|---|
| Arm / unlock | AA@5555, 55@2AAA, A0@5555 |
| Disarm | AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 |

Top module: `swp_seq_detect`

## Requirements
- R1: During and right after `rst_n` low, `res_vld` is 0 and any partial sequence is dropped. A high `prot_init` at a clock edge clears `prot_on` to 0.
- R2: A byte strobed at one clock edge produces exactly one result, visible after that edge. The result has `res_vld`=1 and `res_cur`=1. Kind codes are: 0 hold, 1 data, 2 blocked, 3 command.
- R3: The arm/unlock sequence gives kind 0 for its first two bytes. The A0@5555 byte then gives kind 3 with `res_rel`=2.
- R4: The disarm sequence gives kind 0 for its first five bytes. The 20@5555 byte then gives kind 3 with `res_rel`=5.
- R5: `prot_on` changes only at the `cycle_done` edge that follows a completed sequence, even if no data followed. After an arm sequence it becomes 1; after a disarm sequence it becomes 0.
- R6: With protection off, an ordinary byte gives kind 1 with `res_rel`=0.
- R7: With protection on, a byte that is not preceded by a completed sequence in the current load gives kind 2.
- R8: A byte that does not match the next expected step gives the ordinary kind (1, or 2 when protected) with `res_rel` equal to the number of held bytes. Matching then restarts, and the breaking byte is not reused as a first step.
- R9: If GAP_LIM clock edges pass with no strobe while bytes are held, a result with `res_cur`=0 appears after the GAP_LIM-th idle edge. It carries the ordinary kind and `res_rel` equal to the number of held bytes.
- R10: A pulse on `rst_n` leaves `prot_on` unchanged.
- R11: After a sequence completes, every further byte of that load gives kind 1, including bytes at 5555 or 2AAA with command values. This lasts until `cycle_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequence logic |
| prot_init | input | 1 | Clears the protection flag to its delivery state |
| wr_stb | input | 1 | One-cycle strobe for a captured write byte |
| wr_addr | input | ADDR_W | Address of the captured byte |
| wr_data | input | DATA_W | Data of the captured byte |
| cycle_done | input | 1 | End of the internal write cycle |
| res_vld | output | 1 | A classification result is present |
| res_kind | output | 2 | 0 hold, 1 data, 2 blocked, 3 command |
| res_rel | output | 3 | Number of earlier held bytes settled by this result |
| res_cur | output | 1 | The result covers the byte strobed last |
| prot_on | output | 1 | Protection flag |

## Verification
The hardest situation to reach is a long partial match that is cut short. This means a disarm sequence stopped at step four or five, either by a wrong byte or by the load window running out, while protection is armed. Only then does a release carry a large held count with the blocked kind. Random stimulus from `$urandom` gets there by biasing about a third of its moves toward the correct next command byte. It mixes in idle stretches whose lengths straddle GAP_LIM and bytes aimed at the command addresses with random values. Directed cases first walk the arm, unlock, break, timeout and disarm paths explicitly.

// File: rtl/swp_pkg.sv
package swp_pkg;
    localparam logic [14:0] SEQ_ADDR_A = 15'h5555;
    localparam logic [14:0] SEQ_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  SEQ_B_LEAD = 8'hAA;
    localparam logic [7:0]  SEQ_B_SEC  = 8'h55;
    localparam logic [7:0]  SEQ_B_ARM  = 8'hA0;
    localparam logic [7:0]  SEQ_B_EXT  = 8'h80;
    localparam logic [7:0]  SEQ_B_DIS  = 8'h20;
    localparam int          SEQ_STEPS  = 6;

    typedef enum logic [1:0] {
        K_HOLD  = 2'd0,
        K_DATA  = 2'd1,
        K_BLOCK = 2'd2,
        K_CMD   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        P_NONE = 2'd0,
        P_SET  = 2'd1,
        P_CLR  = 2'd2
    } pend_e;
endpackage

// File: rtl/swp_match.sv
module swp_match
    import swp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int STEP_W = 3
) (
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit,
    output logic              fin_arm,
    output logic              fin_dis
);
    logic [ADDR_W-1:0] a_exp;
    logic [DATA_W-1:0] d_exp;
    logic              arm_here;

    always_comb begin
        case (step)
            STEP_W'(0): begin a_exp = ADDR_W'(SEQ_ADDR_A); d_exp = DATA_W'(SEQ_B_LEAD); end
            STEP_W'(1): begin a_exp = ADDR_W'(SEQ_ADDR_B); d_exp = DATA_W'(SEQ_B_SEC);  end
            STEP_W'(2): begin a_exp = ADDR_W'(SEQ_ADDR_A); d_exp = DATA_W'(SEQ_B_EXT);  end
            STEP_W'(3): begin a_exp = ADDR_W'(SEQ_ADDR_A); d_exp = DATA_W'(SEQ_B_LEAD); end
            STEP_W'(4): begin a_exp = ADDR_W'(SEQ_ADDR_B); d_exp = DATA_W'(SEQ_B_SEC);  end
            default:    begin a_exp = ADDR_W'(SEQ_ADDR_A); d_exp = DATA_W'(SEQ_B_DIS);  end
        endcase
        arm_here = (step == STEP_W'(2)) && (addr == ADDR_W'(SEQ_ADDR_A))
                   && (data == DATA_W'(SEQ_B_ARM));
        hit      = arm_here || ((addr == a_exp) && (data == d_exp));
        fin_arm  = arm_here;
        fin_dis  = hit && (step == STEP_W'(SEQ_STEPS - 1));
    end
endmodule

// File: rtl/swp_gap_timer.sv
module swp_gap_timer #(
    parameter int GAP_LIM = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic armed,
    output logic expire
);
    localparam int CW = $clog2(GAP_LIM + 1);
    localparam logic [CW-1:0] TOP = CW'(GAP_LIM - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (stb) begin
            cnt_d = '0;
        end else begin
            expire = armed && (cnt_q == TOP);
            if (cnt_q != TOP) cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TOP;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/swp_seq_detect.sv
module swp_seq_detect
    import swp_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int GAP_LIM = 7500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_init,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cycle_done,
    output logic              res_vld,
    output logic [1:0]        res_kind,
    output logic [2:0]        res_rel,
    output logic              res_cur,
    output logic              prot_on
);
    localparam int STEP_W = $clog2(SEQ_STEPS + 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              unlock;
        pend_e             pend;
        logic              res_vld;
        kind_e             res_kind;
        logic [2:0]        res_rel;
        logic              res_cur;
    } st_t;

    st_t  st_d, st_q;
    logic prot_d, prot_q;
    logic hit, fin_arm, fin_dis, expire;
    kind_e ord_kind;

    swp_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_match (
        .step    (st_q.step),
        .addr    (wr_addr),
        .data    (wr_data),
        .hit     (hit),
        .fin_arm (fin_arm),
        .fin_dis (fin_dis)
    );

    swp_gap_timer #(.GAP_LIM(GAP_LIM)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (wr_stb),
        .armed  (st_q.step != '0),
        .expire (expire)
    );

    always_comb begin
        st_d          = st_q;
        st_d.res_vld  = 1'b0;
        st_d.res_cur  = 1'b0;
        st_d.res_rel  = '0;
        st_d.res_kind = K_HOLD;
        ord_kind      = (prot_q && !st_q.unlock) ? K_BLOCK : K_DATA;

        if (wr_stb) begin
            st_d.res_vld = 1'b1;
            st_d.res_cur = 1'b1;
            if (st_q.unlock) begin
                st_d.res_kind = K_DATA;
            end else if (hit && (fin_arm || fin_dis)) begin
                st_d.res_kind = K_CMD;
                st_d.res_rel  = 3'(st_q.step);
                st_d.pend     = fin_arm ? P_SET : P_CLR;
                st_d.unlock   = 1'b1;
                st_d.step     = '0;
            end else if (hit) begin
                st_d.res_kind = K_HOLD;
                st_d.step     = st_q.step + STEP_W'(1);
            end else begin
                st_d.res_kind = ord_kind;
                st_d.res_rel  = 3'(st_q.step);
                st_d.step     = '0;
            end
        end else if (expire) begin
            st_d.res_vld  = 1'b1;
            st_d.res_kind = ord_kind;
            st_d.res_rel  = 3'(st_q.step);
            st_d.step     = '0;
        end

        if (cycle_done) begin
            st_d.unlock = 1'b0;
            st_d.pend   = P_NONE;
        end

        prot_d = prot_q;
        if (cycle_done && st_q.pend == P_SET) prot_d = 1'b1;
        if (cycle_done && st_q.pend == P_CLR) prot_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{step: '0, unlock: 1'b0, pend: P_NONE, res_vld: 1'b0,
                      res_kind: K_HOLD, res_rel: '0, res_cur: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Nonvolatile flag: only the initial-state input clears it.
    always_ff @(posedge clk) begin
        if (prot_init) prot_q <= 1'b0;
        else           prot_q <= prot_d;
    end

    assign res_vld  = st_q.res_vld;
    assign res_kind = st_q.res_kind;
    assign res_rel  = st_q.res_rel;
    assign res_cur  = st_q.res_cur;
    assign prot_on  = prot_q;
endmodule

// File: rtl/swp_seq_checker.sv
module swp_seq_checker
    import swp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       prot_init,
    input logic       wr_stb,
    input logic       cycle_done,
    input logic       res_vld,
    input logic [1:0] res_kind,
    input logic [2:0] res_rel,
    input logic       res_cur,
    input logic       prot_on
);
    a_r2_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (res_vld && res_cur));

    a_r3_r4_cmd_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind == K_CMD) |-> (res_cur && (res_rel == 3'd2 || res_rel == 3'd5)));

    a_r5_prot_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cycle_done) && !$past(prot_init)) |-> $stable(prot_on));

    a_r7_block_needs_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind == K_BLOCK) |-> $past(prot_on));

    a_r8_hold_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind == K_HOLD) |-> (res_cur && res_rel == 3'd0));

    a_r9_release_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_cur) |->
            ((res_kind == K_DATA || res_kind == K_BLOCK) && res_rel != 3'd0 && res_rel <= 3'd5));
endmodule

bind swp_seq_detect swp_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prot_init  (prot_init),
    .wr_stb     (wr_stb),
    .cycle_done (cycle_done),
    .res_vld    (res_vld),
    .res_kind   (res_kind),
    .res_rel    (res_rel),
    .res_cur    (res_cur),
    .prot_on    (prot_on)
);

// File: tb/swp_seq_detect_test.sv
module swp_seq_detect_test;
    localparam int GAP = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_init = 1'b1;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cycle_done = 1'b0;
    logic        res_vld, res_cur, prot_on;
    logic [1:0]  res_kind;
    logic [2:0]  res_rel;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // bench model
    int mstep = 0, mpend = 0, mgap = 100;
    bit munlock = 0, mprot = 0;

    always #10 clk = ~clk;

    swp_seq_detect #(.GAP_LIM(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .prot_init(prot_init), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .cycle_done(cycle_done),
        .res_vld(res_vld), .res_kind(res_kind), .res_rel(res_rel),
        .res_cur(res_cur), .prot_on(prot_on)
    );

    function automatic bit step_ok(int s, logic [14:0] a, logic [7:0] d);
        case (s)
            0: return a == 15'h5555 && d == 8'hAA;
            1: return a == 15'h2AAA && d == 8'h55;
            2: return a == 15'h5555 && (d == 8'hA0 || d == 8'h80);
            3: return a == 15'h5555 && d == 8'hAA;
            4: return a == 15'h2AAA && d == 8'h55;
            default: return a == 15'h5555 && d == 8'h20;
        endcase
    endfunction

    function automatic logic [1:0] ord_k();
        return (mprot && !munlock) ? 2'd2 : 2'd1;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // packed result {vld,kind,rel,cur}
    task automatic check_res(logic [6:0] exp, string tag);
        logic [6:0] act;
        act = {res_vld, res_kind, res_rel, res_cur};
        if (!exp[6]) act = {res_vld, 6'd0};
        check(act == exp, tag, 32'(act), 32'(exp));
        check(prot_on == mprot, "R5", 32'(prot_on), 32'(mprot));
    endtask

    task automatic send(logic [14:0] a, logic [7:0] d);
        logic [6:0] e;
        string tag;
        if (munlock) begin
            e = {1'b1, 2'd1, 3'd0, 1'b1}; tag = "R11";
        end else if (step_ok(mstep, a, d) && ((mstep == 2 && d == 8'hA0) || mstep == 5)) begin
            e = {1'b1, 2'd3, 3'(mstep), 1'b1};
            tag = (mstep == 5) ? "R4" : "R3";
            mpend = (mstep == 5) ? 2 : 1;
            munlock = 1; mstep = 0;
        end else if (step_ok(mstep, a, d)) begin
            e = {1'b1, 2'd0, 3'd0, 1'b1}; tag = (mstep >= 2) ? "R4" : "R3";
            mstep++;
        end else begin
            e = {1'b1, ord_k(), 3'(mstep), 1'b1};
            tag = (mstep != 0) ? "R8" : (mprot ? "R7" : "R6");
            mstep = 0;
        end
        mgap = 0;
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        check_res(e, tag);
    endtask

    task automatic idle_model(output logic [6:0] e);
        mgap++;
        e = 7'd0;
        if (mstep > 0 && mgap == GAP) begin
            e = {1'b1, ord_k(), 3'(mstep), 1'b0};
            mstep = 0;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            logic [6:0] e;
            idle_model(e);
            @(negedge clk);
            check_res(e, e[6] ? "R9" : "R2");
        end
    endtask

    task automatic done_pulse();
        logic [6:0] e;
        idle_model(e);
        if (mpend == 1) mprot = 1;
        if (mpend == 2) mprot = 0;
        mpend = 0; munlock = 0;
        cycle_done = 1'b1;
        @(negedge clk);
        cycle_done = 1'b0;
        check_res(e, e[6] ? "R9" : "R5");
    endtask

    task automatic reset_pulse();
        rst_n = 1'b0;
        mstep = 0; munlock = 0; mpend = 0; mgap = 100;
        @(negedge clk);
        @(negedge clk);
        check(res_vld == 1'b0, "R1", 32'(res_vld), 32'd0);
        check(prot_on == mprot, "R10", 32'(prot_on), 32'(mprot));
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        @(negedge clk); @(negedge clk); @(negedge clk);
        prot_init = 1'b0;
        rst_n = 1'b1;
        check(res_vld == 1'b0, "R1", 32'(res_vld), 32'd0);
        check(prot_on == 1'b0, "R1", 32'(prot_on), 32'd0);

        // R6: plain data while unprotected
        send(15'h1234, 8'h5A);
        // R3 then R11 then R5: arm sequence, flag waits for cycle end
        send(15'h5555, 8'hAA);
        send(15'h2AAA, 8'h55);
        send(15'h5555, 8'hA0);
        check(prot_on == 1'b0, "R5", 32'(prot_on), 32'd0);
        send(15'h5555, 8'hAA);
        idle(GAP + 2);
        done_pulse();
        check(prot_on == 1'b1, "R5", 32'(prot_on), 32'd1);
        // R7: blocked write, then unlocked load
        send(15'h0100, 8'h11);
        done_pulse();
        send(15'h5555, 8'hAA);
        send(15'h2AAA, 8'h55);
        send(15'h5555, 8'hA0);
        send(15'h0040, 8'h77);
        done_pulse();
        // R8: break after two held bytes
        send(15'h5555, 8'hAA);
        send(15'h2AAA, 8'h55);
        send(15'h5555, 8'h33);
        send(15'h2AAA, 8'h55);
        // R9: timeout with one held byte
        send(15'h5555, 8'hAA);
        idle(GAP + 1);
        // R10: reset keeps the flag
        reset_pulse();
        // R4: disarm without trailing data
        send(15'h5555, 8'hAA);
        send(15'h2AAA, 8'h55);
        send(15'h5555, 8'h80);
        send(15'h5555, 8'hAA);
        send(15'h2AAA, 8'h55);
        send(15'h5555, 8'h20);
        idle(3);
        done_pulse();
        check(prot_on == 1'b0, "R5", 32'(prot_on), 32'd0);

        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r <= 5) begin
                case (munlock ? 0 : mstep)
                    0, 3: send(15'h5555, 8'hAA);
                    1, 4: send(15'h2AAA, 8'h55);
                    2: send(15'h5555, ($urandom % 2) ? 8'hA0 : 8'h80);
                    default: send(15'h5555, 8'h20);
                endcase
            end else if (r <= 9) begin
                send(15'($urandom), 8'($urandom));
            end else if (r <= 11) begin
                idle(1 + int'($urandom % (GAP + 3)));
            end else if (r == 12) begin
                done_pulse();
            end else if (r == 13) begin
                reset_pulse();
            end else begin
                send(($urandom % 2) ? 15'h5555 : 15'h2AAA, 8'($urandom));
            end
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule